// File: doc/BRIEF.md
# Transaction Queue with Latency-Aware Backpressure

This block buffers incoming transactions in a first-in first-out store and tells the sender to stop through a `stall` output. The sender does not react at once: after it sees `stall` high, it can still present valid entries for a fixed number of cycles, set by the parameter `LAT`. A transaction can also hold `inValid` high for several consecutive cycles, and each of those cycles writes one entry. So `stall` is raised while enough free entries remain to absorb every entry that can still arrive during the sender's reaction window.

The consumer sees the oldest entry on `rdData` whenever `rdValid` is high and removes it by raising `popReq`. A `flush` input empties the whole queue in one cycle. The `occupancy` output reports how many entries are held.

Top module: `txn_queue`

## Requirements
- R1: After reset, `occupancy` is 0 and both `rdValid` and `stall` are low.
- R2: Entries leave in the order they were written, and each `rdData` value equals the written `inData` value.
- R3: `occupancy` never exceeds `DEPTH`. A write presented while `occupancy` equals `DEPTH` and no pop is taken is dropped: `occupancy` stays at `DEPTH` and the stored entries are unchanged.
- R4: `stall` is high exactly when `occupancy` is at least `DEPTH - LAT - 1` (5 with the defaults `DEPTH=8` and `LAT=2`).
- R5: Suppose a sender starts from an empty queue, writes one entry every cycle, and keeps `inValid` high in the cycle where `stall` is first seen high and for `LAT` cycles after it. Then all of its entries are stored, with none lost, and `occupancy` ends at exactly `DEPTH`.
- R6: When `flush` is high, `occupancy` is 0 and `rdValid` is low on the next cycle. A write or pop presented in the same cycle as `flush` has no effect.
- R7: A write and a pop taken in the same cycle on a non-empty queue leave `occupancy` unchanged. This also holds when the queue is full.
- R8: A pop on an empty queue is ignored. A write and a pop presented together on an empty queue store the entry and give `occupancy` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Write-side entry present this cycle |
| inData | input | DATA_W | Write-side entry value |
| popReq | input | 1 | Remove the oldest entry |
| flush | input | 1 | Empty the queue |
| rdData | output | DATA_W | Oldest entry |
| rdValid | output | 1 | Queue holds at least one entry |
| occupancy | output | $clog2(DEPTH+1) | Number of entries held |
| stall | output | 1 | Backpressure to the sender |

## Verification
A write and a pop can fall in the same cycle. The bench provokes this on a half-full queue, on a full queue and on an empty queue. In each case it checks `occupancy` after the edge and checks that the popped value is the expected head entry. It also puts a write in the same cycle as `flush` and checks that the write leaves no trace. A sender model honours `stall` with exactly `LAT` cycles of lag, which shows that the threshold leaves room for the entries already in flight.

// File: rtl/txn_queue_pkg.sv
package txn_queue_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic clr;
  } qStrobe_t;
endpackage

// File: rtl/txn_queue_ctrl.sv
module txn_queue_ctrl
  import txn_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LAT   = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             popReq,
  input  logic             flush,
  output qStrobe_t         strb,
  output logic [CNT_W-1:0] count,
  output logic             stall
);
  // Entries that can still land once stall is up: the current cycle plus LAT.
  localparam int INFLIGHT = LAT + 1;
  localparam int STALL_AT = DEPTH - INFLIGHT;

  logic full, empty;
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_comb begin
    strb.clr  = flush;
    strb.rdEn = popReq && !empty && !flush;
    strb.wrEn = inValid && !flush && (!full || strb.rdEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          count <= '0;
    else if (strb.clr)  count <= '0;
    else                count <= count + CNT_W'(strb.wrEn) - CNT_W'(strb.rdEn);
  end

  assign stall = (count >= CNT_W'(STALL_AT));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && inValid && !popReq && !flush) |=> (count == CNT_W'(DEPTH)));
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  p_push_pop_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && popReq && !empty && !flush) |=> $stable(count));
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (empty && popReq && !inValid && !flush) |=> (count == '0));
endmodule

// File: rtl/txn_queue_dp.sv
module txn_queue_dp
  import txn_queue_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= bump(wrPtr);
      if (strb.rdEn) rdPtr <= bump(rdPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.wrEn && wrPtr == PTR_W'(i)) store[i] <= inData;
    end
  end

  assign rdData = store[rdPtr];

  p_flush_ptrs_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (wrPtr == rdPtr));
  p_pop_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.clr) |=> (rdPtr != $past(rdPtr)) || (DEPTH == 1));
endmodule

// File: rtl/txn_queue.sv
module txn_queue
  import txn_queue_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LAT    = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              popReq,
  input  logic              flush,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [CNT_W-1:0]  occupancy,
  output logic              stall
);
  qStrobe_t strb;

  txn_queue_ctrl #(.DEPTH(DEPTH), .LAT(LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .popReq(popReq),
    .flush(flush), .strb(strb), .count(occupancy), .stall(stall)
  );

  txn_queue_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .rdData(rdData)
  );

  assign rdValid = (occupancy != '0);

  p_valid_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdValid) |-> ($past(flush) || $past(popReq)));
endmodule

// File: tb/sim_txn_queue.sv
`timescale 1ns/1ps
module sim_txn_queue;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int LAT    = 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int STALL_AT = DEPTH - LAT - 1;

  logic clk = 1'b0;
  logic rstN;
  logic inValid, popReq, flush;
  logic [DATA_W-1:0] inData;
  logic [DATA_W-1:0] rdData;
  logic rdValid, stall;
  logic [CNT_W-1:0] occupancy;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  txn_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .popReq(popReq), .flush(flush), .rdData(rdData), .rdValid(rdValid),
    .occupancy(occupancy), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one clock and settle just after the edge.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    inValid = 1'b0; popReq = 1'b0; flush = 1'b0; inData = '0;
  endtask

  task automatic doFlush();
    idle(); flush = 1'b1; cyc(); idle();
  endtask

  task automatic push(input int v);
    idle(); inValid = 1'b1; inData = DATA_W'(v); cyc(); idle();
  endtask

  task automatic popExpect(input string req, input int v);
    check(req, int'(rdValid), 1);
    check(req, int'(rdData), v);
    idle(); popReq = 1'b1; cyc(); idle();
  endtask

  task automatic t_reset();
    check("R1 occupancy", int'(occupancy), 0);
    check("R1 rdValid", int'(rdValid), 0);
    check("R1 stall", int'(stall), 0);
  endtask

  // Fill while ignoring stall; watch threshold and full-drop behaviour.
  task automatic t_fill_overflow();
    doFlush();
    for (int i = 0; i < DEPTH; i++) begin
      push(100 + i);
      check("R4 stall threshold", int'(stall), int'((i + 1) >= STALL_AT));
    end
    check("R3 occupancy full", int'(occupancy), DEPTH);
    push(900);
    push(901);
    check("R3 occupancy capped", int'(occupancy), DEPTH);
    for (int i = 0; i < DEPTH; i++) popExpect("R2/R3 order after drop", 100 + i);
    check("R2 drained", int'(occupancy), 0);
    check("R4 stall low when empty", int'(stall), 0);
  endtask

  // Sender that reacts to stall after LAT cycles.
  task automatic t_latency_sender();
    int sent = 0;
    int after = -1;
    doFlush();
    forever begin
      if (after < 0 && stall) after = 0;
      if (after > LAT) break;
      inValid = 1'b1; inData = DATA_W'(200 + sent); popReq = 1'b0; flush = 1'b0;
      sent++;
      cyc();
      if (after >= 0) after++;
    end
    idle();
    check("R5 entries sent", sent, DEPTH);
    check("R5 occupancy at depth", int'(occupancy), DEPTH);
    for (int i = 0; i < sent; i++) popExpect("R5 no entry lost", 200 + i);
  endtask

  task automatic t_push_pop();
    doFlush();
    for (int i = 0; i < 4; i++) push(300 + i);
    idle(); inValid = 1'b1; inData = DATA_W'(304); popReq = 1'b1; cyc(); idle();
    check("R7 half-full hold", int'(occupancy), 4);
    for (int i = 4; i < DEPTH; i++) push(300 + i + 1);
    check("R7 full reached", int'(occupancy), DEPTH);
    check("R7 head at full", int'(rdData), 301);
    idle(); inValid = 1'b1; inData = DATA_W'(399); popReq = 1'b1; cyc(); idle();
    check("R7 full hold", int'(occupancy), DEPTH);
    for (int i = 2; i <= DEPTH; i++) popExpect("R7 order", 300 + i);
    popExpect("R7 wrote while full", 399);
    check("R7 drained", int'(occupancy), 0);
  endtask

  task automatic t_empty_pop();
    doFlush();
    idle(); popReq = 1'b1; cyc(); idle();
    check("R8 pop empty ignored", int'(occupancy), 0);
    check("R8 rdValid low", int'(rdValid), 0);
    idle(); popReq = 1'b1; inValid = 1'b1; inData = DATA_W'(555); cyc(); idle();
    check("R8 push+pop empty", int'(occupancy), 1);
    popExpect("R8 stored value", 555);
  endtask

  task automatic t_flush();
    doFlush();
    for (int i = 0; i < 5; i++) push(600 + i);
    idle(); flush = 1'b1; inValid = 1'b1; inData = DATA_W'(777); popReq = 1'b1; cyc(); idle();
    check("R6 occupancy zero", int'(occupancy), 0);
    check("R6 rdValid low", int'(rdValid), 0);
    check("R6 stall low", int'(stall), 0);
    push(42);
    check("R6 write in flush cycle dropped", int'(occupancy), 1);
    popExpect("R6 fresh head", 42);
  endtask

  initial begin
    idle();
    rstN = 1'b0;
    #1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    cyc();
    t_reset();
    t_fill_overflow();
    t_latency_sender();
    t_push_pop();
    t_empty_pop();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule